// File: doc/BRIEF.md
# Character LCD Write Sequencer

This block drives an 8-bit parallel character display over a write-only bus made of a data byte, a register-select line, a read/write line tied low, and an enable strobe. A single pulse on `start` makes it write a fixed power-on set of five command bytes and then the five character codes of the word HELLO. Each byte is written with one timed enable pulse. The block raises `done` for one cycle when the last character has been written, and then waits for the next `start`.

The block never polls the display's busy flag. Fixed waits, counted in clock cycles, stand in for it. Four parameters set these waits:
- how long data is presented before the strobe rises,
- how long the strobe stays high,
- the short gap that follows most bytes,
- a long wait that follows the clear command.

A parameter of zero is raised to one cycle, so every wait lasts at least one cycle. This prevents a zero-width strobe and a zero-cycle setup or hold.

Each byte is written as three timed steps:
1. The byte and its register-select value are driven onto the bus, with the strobe low, for the setup time.
2. The strobe is held high for the strobe width.
3. The strobe drops. The display captures the byte on this falling edge. The bus then holds its value through the gap.

A sequencer steps a ten-entry table through this writer. Each table entry holds the byte, its register-select value and a flag that selects the long wait.

Top module: `lcd_write_seq`

## Requirements
- R1: While reset is held and right after it is released, `lcd_en`, `lcd_rs`, `lcd_rnw`, `done` and `lcd_db` are all 0.
- R2: After `start`, the first five bytes latched (at the falling edges of `lcd_en`) are 38h, 0Eh, 01h, 06h and 80h, in that order, each with `lcd_rs`=0.
- R3: The next five bytes latched are 48h, 45h, 4Ch, 4Ch and 4Fh, each with `lcd_rs`=1. A run latches exactly ten bytes.
- R4: `lcd_rnw` is 0 in every cycle.
- R5: `lcd_db` and `lcd_rs` settle at least SETUP_CYC cycles (minimum 1) before `lcd_en` rises. They do not change while `lcd_en` is high, nor in the cycle in which it falls.
- R6: `lcd_en` stays high for exactly E_HIGH_CYC cycles (minimum 1) in every pulse.
- R7: From one falling edge of `lcd_en` to the next rising edge, the time is GAP+2+SETUP cycles. GAP is CLEAR_WAIT_CYC after the clear byte (01h) and GAP_CYC after every other byte, each with a minimum of 1.
- R8: `done` is high for exactly one cycle. That cycle follows the clock edge that samples `start` by the sum, over all ten bytes, of SETUP+E_HIGH+GAP+2 cycles.
- R9: A `start` sampled while a run is in progress, up to and including the edge that raises `done`, is ignored. Its run still produces one `done` and ten bytes at the normal times.
- R10: Between the end of a run and the next accepted `start`, `lcd_en` stays low and `done` does not rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a run when sampled high while idle |
| lcd_db | output | 8 | Byte driven to the display |
| lcd_rs | output | 1 | Register select: 0 for a command, 1 for a character |
| lcd_rnw | output | 1 | Read/write select, always 0 (write) |
| lcd_en | output | 1 | Enable strobe; the display latches on its falling edge |
| done | output | 1 | One-cycle pulse after the last character |

## Verification
The checker's record of whether a run is in progress depends only on `start` and `done`. It assumes that `start` is a synchronous, single-bit input sampled on the rising clock edge. It also assumes that reset is not applied in the middle of a run, because a mid-run reset would leave that record stale. The stimulus changes `start` only on falling clock edges and applies reset only once, at time zero. Starts that land while the block is busy therefore reach the block and the checker in the same cycle. The bench sweeps the offset of a second `start` pulse across every cycle of a run, from the first cycle through the cycle that raises `done`. It uses a small timing configuration, so that the arithmetic expectations for every edge of the strobe can be checked in each sweep.

// File: rtl/lcd_seq_pkg.sv
// Shared types and the write table for the display write sequencer.
// Assumes a fixed ten-byte run: five setup commands followed by five characters.
package lcd_seq_pkg;

    localparam int unsigned N_STEPS = 10;
    localparam int unsigned IDX_W   = $clog2(N_STEPS);
    localparam int unsigned TBL_LEN = 1 << IDX_W;

    // One table entry: register select, long-wait flag, byte.
    typedef struct packed {
        logic       rs;
        logic       long_wait;
        logic [7:0] code;
    } lcd_step_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_SETUP = 2'd1,
        W_PULSE = 2'd2,
        W_GAP   = 2'd3
    } writer_state_t;

    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_ISSUE = 2'd1,
        Q_WAIT  = 2'd2
    } seq_state_t;

    // Table contents; indices past the run return an empty entry.
    function automatic lcd_step_t step_at(input int unsigned i);
        lcd_step_t s;
        s = '0;
        case (i)
            0: s.code = 8'h38;
            1: s.code = 8'h0E;
            2: begin s.code = 8'h01; s.long_wait = 1'b1; end
            3: s.code = 8'h06;
            4: s.code = 8'h80;
            5: begin s.code = 8'h48; s.rs = 1'b1; end
            6: begin s.code = 8'h45; s.rs = 1'b1; end
            7: begin s.code = 8'h4C; s.rs = 1'b1; end
            8: begin s.code = 8'h4C; s.rs = 1'b1; end
            9: begin s.code = 8'h4F; s.rs = 1'b1; end
            default: s = '0;
        endcase
        return s;
    endfunction

    // Raises a cycle count to at least one.
    function automatic int unsigned at_least_one(input int unsigned v);
        return (v < 1) ? 1 : v;
    endfunction

    // Largest of four counts, used to size the shared timer.
    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lcd_seq_rom.sv
// Combinational lookup of the write table.
// Assumes idx is below N_STEPS during a run; other indices read an empty entry.
module lcd_seq_rom
    import lcd_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output lcd_step_t        step
);

    lcd_step_t table_w [TBL_LEN];

    // Fill every table slot from the package function.
    for (genvar g = 0; g < TBL_LEN; g++) begin : g_slot
        assign table_w[g] = step_at(g);
    end

    // Select the entry for the current index.
    assign step = table_w[idx];

endmodule

// File: rtl/lcd_seq_timer.sv
// Phase length counter. A load of N marks a phase lasting N cycles; expired
// is high in the last of them.
// Assumes load_val is at least 1.
module lcd_seq_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Load the remaining count, or count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/lcd_seq_writer.sv
// Writes one byte to the display bus: setup with the strobe low, the strobe
// high, then a gap with the bus held. fin pulses as the writer returns to idle.
// Assumes go is offered only while the writer is idle, and that all phase
// lengths are at least 1.
module lcd_seq_writer
    import lcd_seq_pkg::*;
#(
    parameter int unsigned SETUP_LEN = 2,
    parameter int unsigned E_LEN     = 4,
    parameter int unsigned GAP_LEN   = 8,
    parameter int unsigned CLR_LEN   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] code,
    input  logic       rs,
    input  logic       long_wait,
    output logic [7:0] lcd_db,
    output logic       lcd_rs,
    output logic       lcd_en,
    output logic       fin
);

    localparam int unsigned MAXLEN = max4(SETUP_LEN, E_LEN, GAP_LEN, CLR_LEN);
    localparam int unsigned TW     = $clog2(MAXLEN + 1);

    writer_state_t st_q;
    logic          long_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;

    lcd_seq_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // Pick the length of the phase that starts on this edge.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TW'(SETUP_LEN);
        case (st_q)
            W_IDLE: begin
                if (go) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_LEN);
                end
            end
            W_SETUP: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(E_LEN);
                end
            end
            W_PULSE: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = long_q ? TW'(CLR_LEN) : TW'(GAP_LEN);
                end
            end
            default: begin
                tmr_load = 1'b0;
            end
        endcase
    end

    // Step the phases and drive the registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= W_IDLE;
            long_q <= 1'b0;
            lcd_db <= '0;
            lcd_rs <= 1'b0;
            lcd_en <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st_q)
                W_IDLE: begin
                    if (go) begin
                        lcd_db <= code;
                        lcd_rs <= rs;
                        long_q <= long_wait;
                        st_q   <= W_SETUP;
                    end
                end
                W_SETUP: begin
                    if (tmr_exp) begin
                        lcd_en <= 1'b1;
                        st_q   <= W_PULSE;
                    end
                end
                W_PULSE: begin
                    if (tmr_exp) begin
                        lcd_en <= 1'b0;
                        st_q   <= W_GAP;
                    end
                end
                W_GAP: begin
                    if (tmr_exp) begin
                        fin  <= 1'b1;
                        st_q <= W_IDLE;
                    end
                end
                default: st_q <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_write_seq.sv
// Top of the display write sequencer. On start, walks the ten-entry table
// through the byte writer, then pulses done and idles.
// Assumes start is synchronous to clk. Starts that arrive during a run are
// dropped.
module lcd_write_seq
    import lcd_seq_pkg::*;
#(
    parameter int unsigned SETUP_CYC      = 2,
    parameter int unsigned E_HIGH_CYC     = 60,
    parameter int unsigned GAP_CYC        = 5000,
    parameter int unsigned CLEAR_WAIT_CYC = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic [7:0] lcd_db,
    output logic       lcd_rs,
    output logic       lcd_rnw,
    output logic       lcd_en,
    output logic       done
);

    localparam int unsigned SETUP_LEN = at_least_one(SETUP_CYC);
    localparam int unsigned E_LEN     = at_least_one(E_HIGH_CYC);
    localparam int unsigned GAP_LEN   = at_least_one(GAP_CYC);
    localparam int unsigned CLR_LEN   = at_least_one(CLEAR_WAIT_CYC);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STEPS - 1);

    seq_state_t       sq_q;
    logic [IDX_W-1:0] idx_q;
    lcd_step_t        cur_step;
    logic             go;
    logic             fin;

    lcd_seq_rom u_rom (
        .idx  (idx_q),
        .step (cur_step)
    );

    lcd_seq_writer #(
        .SETUP_LEN (SETUP_LEN),
        .E_LEN     (E_LEN),
        .GAP_LEN   (GAP_LEN),
        .CLR_LEN   (CLR_LEN)
    ) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .code      (cur_step.code),
        .rs        (cur_step.rs),
        .long_wait (cur_step.long_wait),
        .lcd_db    (lcd_db),
        .lcd_rs    (lcd_rs),
        .lcd_en    (lcd_en),
        .fin       (fin)
    );

    // The bus is write-only.
    assign lcd_rnw = 1'b0;

    // Hand the current entry to the writer for exactly one cycle.
    assign go = (sq_q == Q_ISSUE);

    // Walk the table and raise done after the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q  <= Q_IDLE;
            idx_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (sq_q)
                Q_IDLE: begin
                    if (start) begin
                        idx_q <= '0;
                        sq_q  <= Q_ISSUE;
                    end
                end
                Q_ISSUE: begin
                    sq_q <= Q_WAIT;
                end
                Q_WAIT: begin
                    if (fin) begin
                        if (idx_q == LAST_IDX) begin
                            done <= 1'b1;
                            sq_q <= Q_IDLE;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                            sq_q  <= Q_ISSUE;
                        end
                    end
                end
                default: sq_q <= Q_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_write_seq_chk.sv
// Protocol checker for lcd_write_seq, attached with bind.
// Assumes start is synchronous and that reset is not applied in mid-run.
module lcd_write_seq_chk #(
    parameter int unsigned E_HIGH_CYC = 60
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] lcd_db,
    input logic       lcd_rs,
    input logic       lcd_en,
    input logic       done
);

    localparam int unsigned EW = (E_HIGH_CYC < 1) ? 1 : E_HIGH_CYC;

    logic        busy_q;
    logic        en_q;
    int unsigned hi_cnt;
    int unsigned fall_cnt;
    logic        accept;

    assign accept = start && (!busy_q || done);

    // Track whether a run is in progress, as seen from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (done) begin
            busy_q <= start;
        end else if (start) begin
            busy_q <= 1'b1;
        end
    end

    // Count strobe-high cycles and the falling edges seen in a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            hi_cnt   <= 0;
            fall_cnt <= 0;
        end else begin
            en_q   <= lcd_en;
            hi_cnt <= lcd_en ? hi_cnt + 1 : 0;
            if (accept)
                fall_cnt <= 0;
            else if (en_q && !lcd_en)
                fall_cnt <= fall_cnt + 1;
        end
    end

    p_setup_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en |=> ($stable(lcd_db) && $stable(lcd_rs)));

    p_strobe_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |-> (hi_cnt == EW));

    p_clear_is_command_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && lcd_db == 8'h01) |-> !lcd_rs);

    p_ten_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fall_cnt == 10));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !lcd_en);

endmodule

bind lcd_write_seq lcd_write_seq_chk #(.E_HIGH_CYC(E_HIGH_CYC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .lcd_db (lcd_db),
    .lcd_rs (lcd_rs),
    .lcd_en (lcd_en),
    .done   (done)
);

// File: tb/sim_lcd_write_seq.sv
`timescale 1ns/1ps
// Bench for lcd_write_seq: one plain run, then a sweep of a second start
// pulse over every busy cycle, with all edge timing computed from parameters.
module sim_lcd_write_seq;

    localparam int S  = 2;
    localparam int EW = 3;
    localparam int G  = 4;
    localparam int W  = 20;
    localparam int N  = 10;
    localparam int SUMP = N * (S + EW + 2) + (N - 1) * G + W;
    localparam int WDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] lcd_db;
    logic       lcd_rs;
    logic       lcd_rnw;
    logic       lcd_en;
    logic       done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit mon_on = 0;
    int nbytes = 0;
    int rises = 0;
    int dones = 0;
    int chg_cyc = 0;
    int rise_cyc = 0;
    int fall_cyc = 0;
    logic [7:0] pd = 8'h00;
    logic       prs = 1'b0;
    logic       pe = 1'b0;

    lcd_write_seq #(
        .SETUP_CYC      (S),
        .E_HIGH_CYC     (EW),
        .GAP_CYC        (G),
        .CLEAR_WAIT_CYC (W)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .lcd_db  (lcd_db),
        .lcd_rs  (lcd_rs),
        .lcd_rnw (lcd_rnw),
        .lcd_en  (lcd_en),
        .done    (done)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] exp_code(input int i);
        case (i)
            0: return 8'h38;
            1: return 8'h0E;
            2: return 8'h01;
            3: return 8'h06;
            4: return 8'h80;
            5: return "H";
            6: return "E";
            7: return "L";
            8: return "L";
            9: return "O";
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Bus monitor, sampled between clock edges.
    always @(negedge clk) begin
        if (mon_on) begin
            if (lcd_rnw !== 1'b0) chk(0, "R4", int'(lcd_rnw), 0);
            if (done) dones++;
            if ((lcd_db !== pd) || (lcd_rs !== prs)) begin
                if (lcd_en || pe) chk(0, "R5", cyc, fall_cyc + 1);
                chg_cyc = cyc;
            end
            if (lcd_en && !pe) begin
                rises++;
                rise_cyc = cyc;
                chk(cyc - chg_cyc >= S, "R5", cyc - chg_cyc, S);
                if (nbytes > 0 && nbytes < N)
                    chk(cyc - fall_cyc == ((nbytes - 1 == 2) ? W : G) + 2 + S,
                        "R7", cyc - fall_cyc, ((nbytes - 1 == 2) ? W : G) + 2 + S);
            end
            if (!lcd_en && pe) begin
                chk(cyc - rise_cyc == EW, "R6", cyc - rise_cyc, EW);
                if (nbytes < 5) begin
                    chk(lcd_db == exp_code(nbytes), "R2", lcd_db, exp_code(nbytes));
                    chk(lcd_rs == 1'b0, "R2", lcd_rs, 0);
                end else begin
                    chk(lcd_db == exp_code(nbytes), "R3", lcd_db, exp_code(nbytes));
                    chk(lcd_rs == 1'b1, "R3", lcd_rs, 1);
                end
                nbytes++;
                fall_cyc = cyc;
            end
        end
        pd  = lcd_db;
        prs = lcd_rs;
        pe  = lcd_en;
    end

    // One run; k > 0 adds a second start pulse sampled k cycles after the first.
    task automatic run(input int k);
        int a;
        int b;
        bit seen;
        string req;
        req = (k > 0) ? "R9" : "R8";
        @(negedge clk);
        nbytes = 0;
        rises = 0;
        dones = 0;
        chg_cyc = cyc;
        a = cyc;
        seen = 0;
        b = 0;
        start = 1'b1;
        for (int t = 0; t < SUMP + 50 && !seen; t++) begin
            @(negedge clk);
            start = (k > 0 && cyc == a + k) ? 1'b1 : 1'b0;
            if (done) begin
                seen = 1;
                b = cyc;
            end
        end
        start = 1'b0;
        chk(seen && (b - (a + 1) == SUMP), req, b - (a + 1), SUMP);
        @(negedge clk);
        chk(done == 1'b0, "R8", done, 0);
        chk(nbytes == N, "R3", nbytes, N);
        repeat (8) @(negedge clk);
        chk(rises == N, (k > 0) ? "R9" : "R10", rises, N);
        chk(dones == 1, (k > 0) ? "R9" : "R10", dones, 1);
        chk(lcd_en == 1'b0, "R10", lcd_en, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk(lcd_en == 1'b0, "R1", lcd_en, 0);
        chk(lcd_rs == 1'b0, "R1", lcd_rs, 0);
        chk(lcd_rnw == 1'b0, "R1", lcd_rnw, 0);
        chk(done == 1'b0, "R1", done, 0);
        chk(lcd_db == 8'h00, "R1", lcd_db, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: outputs after release
        chk(lcd_en == 1'b0 && done == 1'b0, "R1", {lcd_en, done}, 0);
        chk(lcd_db == 8'h00, "R1", lcd_db, 0);
        pd = lcd_db;
        prs = lcd_rs;
        pe = lcd_en;
        mon_on = 1;
        run(0);
        for (int k = 1; k <= SUMP; k++) run(k);
        run(0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule